// File: doc/BRIEF.md
# Peripheral Module Disable Gate

A bank of per-peripheral disable bits that controls whether each peripheral is clocked and whether its registers can be reached. Software writes a disable vector through a simple write port. The vector is held in a control register, and that register can be read back at any time. The bits do not act at once. They are copied into an applied-enable stage only on a pulse of the instruction-cycle strobe, so any change reaches the peripherals one instruction cycle after the write.

A module counts as active only when two things are true: its disable bit is clear, and it is built into this variant. The build-time present mask says which modules exist. Absent modules are forced disabled, and their disable bits always read as 1. An inactive module gets no clock enable. Register writes aimed at it are discarded. A register read aimed at it returns zeros, with the read-valid flag low.

Top module: `pmd_gate`

## Requirements
- R1: After reset, `dis_rdata_o` equals the inverse of `PRESENT_MASK`, and `mod_clk_en_o` equals `PRESENT_MASK`. Every present module is enabled.
- R2: A clock edge with `dis_we_i` high loads the disable register. From that edge on, `dis_rdata_o` reads `dis_wdata_i | ~PRESENT_MASK`. Bits of absent modules stay 1 even when written 0. Without `dis_we_i`, the register holds.
- R3: `mod_clk_en_o` changes only at a clock edge where `cycle_i` is high. At such an edge it becomes `~dis_rdata_o & PRESENT_MASK`, using the register value from before that edge. A disable change written at the same edge as a strobe waits for the next strobe.
- R4: `mod_clk_en_o[i]` is never 1 for a module whose `PRESENT_MASK[i]` is 0.
- R5: `mod_wr_o[i]` follows `bus_wr_i[i]` in the same cycle when module i is enabled. It is 0 when module i is disabled, so the write is dropped.
- R6: A read strobe in `bus_rd_i` (at most one bit set) behaves as follows. If it selects an enabled module, `bus_rdata_o` carries that module's slice of `mod_rdata_i` (bits `i*DATA_W` upward) and `bus_rd_valid_o` is 1. If it selects a disabled module, `bus_rdata_o` is all zeros and `bus_rd_valid_o` is 0.
- R7: With no read strobe, `bus_rdata_o` is zero and `bus_rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_i | input | 1 | Instruction-cycle strobe, one clock per instruction cycle |
| dis_we_i | input | 1 | Disable register write enable |
| dis_wdata_i | input | NUM_MODS | Disable vector to write, 1 = disable |
| dis_rdata_o | output | NUM_MODS | Disable register readback |
| mod_clk_en_o | output | NUM_MODS | Applied per-module clock enable |
| bus_wr_i | input | NUM_MODS | Per-module register write strobe from the bus |
| mod_wr_o | output | NUM_MODS | Gated per-module write strobe |
| bus_rd_i | input | NUM_MODS | Per-module register read strobe, one-hot or zero |
| mod_rdata_i | input | NUM_MODS*DATA_W | Read data from all modules, concatenated |
| bus_rdata_o | output | DATA_W | Read data returned to the bus |
| bus_rd_valid_o | output | 1 | Read data is valid |

## Verification
Several rules are checked on every cycle: absent modules never receive a clock enable, clock enables move only on strobe edges and take the previous register value, the write port produces the masked readback, no gated write reaches a disabled module, and zero read data goes with a low valid flag. Some behaviours can only be shown by the bench's scenarios, because the bench compares against a model it keeps itself. These are the one-strobe lag after a write (including a write on the same edge as a strobe), the exact slice returned for each enabled module, and the reset values.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int unsigned NUM_MODS_DEF = 8;
  localparam int unsigned DATA_W_DEF   = 16;
  localparam logic [7:0]  PRESENT_DEF  = 8'hB7;
endpackage

// File: rtl/pmd_dis_reg.sv
module pmd_dis_reg #(
  parameter int unsigned NUM_MODS = 8,
  parameter logic [NUM_MODS-1:0] PRESENT_MASK = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_MODS-1:0] wdata_i,
  output logic [NUM_MODS-1:0] dis_o
);
  localparam logic [NUM_MODS-1:0] ABSENT = ~PRESENT_MASK;

  logic [NUM_MODS-1:0] dis_q;

  // absent modules are pinned disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dis_q <= ABSENT;
    else if (we_i) dis_q <= wdata_i | ABSENT;
  end

  assign dis_o = dis_q;
endmodule

// File: rtl/pmd_apply.sv
module pmd_apply #(
  parameter int unsigned NUM_MODS = 8,
  parameter logic [NUM_MODS-1:0] PRESENT_MASK = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cycle_i,
  input  logic [NUM_MODS-1:0] dis_i,
  output logic [NUM_MODS-1:0] en_o
);
  logic [NUM_MODS-1:0] en_q;

  // one instruction-cycle application delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= PRESENT_MASK;
    else if (cycle_i) en_q <= ~dis_i & PRESENT_MASK;
  end

  assign en_o = en_q;
endmodule

// File: rtl/pmd_access.sv
module pmd_access #(
  parameter int unsigned NUM_MODS = 8,
  parameter int unsigned DATA_W   = 16
) (
  input  logic [NUM_MODS-1:0]        en_i,
  input  logic [NUM_MODS-1:0]        wr_i,
  input  logic [NUM_MODS-1:0]        rd_i,
  input  logic [NUM_MODS*DATA_W-1:0] rdata_i,
  output logic [NUM_MODS-1:0]        wr_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rvalid_o
);
  logic [NUM_MODS-1:0] rd_sel;
  logic [DATA_W-1:0]   masked [NUM_MODS];

  assign wr_o = wr_i & en_i;

  for (genvar g = 0; g < NUM_MODS; g++) begin : g_mod
    assign rd_sel[g] = rd_i[g] & en_i[g];
    assign masked[g] = rdata_i[g*DATA_W +: DATA_W] & {DATA_W{rd_sel[g]}};
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_MODS; i++) rdata_o = rdata_o | masked[i];
  end

  assign rvalid_o = |rd_sel;
endmodule

// File: rtl/pmd_gate.sv
module pmd_gate #(
  parameter int unsigned NUM_MODS = pmd_pkg::NUM_MODS_DEF,
  parameter int unsigned DATA_W   = pmd_pkg::DATA_W_DEF,
  parameter logic [NUM_MODS-1:0] PRESENT_MASK = NUM_MODS'(pmd_pkg::PRESENT_DEF)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cycle_i,
  input  logic                       dis_we_i,
  input  logic [NUM_MODS-1:0]        dis_wdata_i,
  output logic [NUM_MODS-1:0]        dis_rdata_o,
  output logic [NUM_MODS-1:0]        mod_clk_en_o,
  input  logic [NUM_MODS-1:0]        bus_wr_i,
  output logic [NUM_MODS-1:0]        mod_wr_o,
  input  logic [NUM_MODS-1:0]        bus_rd_i,
  input  logic [NUM_MODS*DATA_W-1:0] mod_rdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic                       bus_rd_valid_o
);
  logic [NUM_MODS-1:0] dis;
  logic [NUM_MODS-1:0] en;

  pmd_dis_reg #(.NUM_MODS(NUM_MODS), .PRESENT_MASK(PRESENT_MASK)) u_dis (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dis_we_i),
    .wdata_i (dis_wdata_i),
    .dis_o   (dis)
  );

  pmd_apply #(.NUM_MODS(NUM_MODS), .PRESENT_MASK(PRESENT_MASK)) u_apply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cycle_i (cycle_i),
    .dis_i   (dis),
    .en_o    (en)
  );

  pmd_access #(.NUM_MODS(NUM_MODS), .DATA_W(DATA_W)) u_access (
    .en_i     (en),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .rdata_i  (mod_rdata_i),
    .wr_o     (mod_wr_o),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rd_valid_o)
  );

  assign dis_rdata_o  = dis;
  assign mod_clk_en_o = en;
endmodule

// File: rtl/pmd_gate_chk.sv
module pmd_gate_chk #(
  parameter int unsigned NUM_MODS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter logic [NUM_MODS-1:0] PRESENT_MASK = '1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cycle_i,
  input logic                dis_we_i,
  input logic [NUM_MODS-1:0] dis_wdata_i,
  input logic [NUM_MODS-1:0] dis_rdata_o,
  input logic [NUM_MODS-1:0] mod_clk_en_o,
  input logic [NUM_MODS-1:0] mod_wr_o,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic                bus_rd_valid_o
);
  assert_wr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_we_i |=> dis_rdata_o == ($past(dis_wdata_i) | ~PRESENT_MASK));

  assert_dis_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_we_i |=> $stable(dis_rdata_o));

  assert_en_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_i |=> $stable(mod_clk_en_o));

  assert_en_apply_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_i |=> mod_clk_en_o == (~$past(dis_rdata_o) & PRESENT_MASK));

  assert_absent_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_clk_en_o & ~PRESENT_MASK) == '0);

  assert_wr_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_wr_o & ~mod_clk_en_o) == '0);

  assert_rd_invalid_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_valid_o |-> bus_rdata_o == '0);
endmodule

bind pmd_gate pmd_gate_chk #(
  .NUM_MODS(NUM_MODS), .DATA_W(DATA_W), .PRESENT_MASK(PRESENT_MASK)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cycle_i        (cycle_i),
  .dis_we_i       (dis_we_i),
  .dis_wdata_i    (dis_wdata_i),
  .dis_rdata_o    (dis_rdata_o),
  .mod_clk_en_o   (mod_clk_en_o),
  .mod_wr_o       (mod_wr_o),
  .bus_rdata_o    (bus_rdata_o),
  .bus_rd_valid_o (bus_rd_valid_o)
);

// File: tb/tb_pmd_gate.sv
`timescale 1ns/1ps
module tb_pmd_gate;
  localparam int unsigned N  = 8;
  localparam int unsigned DW = 16;
  localparam logic [N-1:0] PRES = 8'hB7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, we = 1'b0;
  logic [N-1:0] wdata = '0, bwr = '0, brd = '0;
  logic [N*DW-1:0] mrdata = '0;
  logic [N-1:0] dis_rd, clk_en, mwr;
  logic [DW-1:0] rdata;
  logic rvalid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_dis, exp_en;

  always #2 clk = ~clk;

  pmd_gate #(.NUM_MODS(N), .DATA_W(DW), .PRESENT_MASK(PRES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cyc), .dis_we_i(we), .dis_wdata_i(wdata),
    .dis_rdata_o(dis_rd), .mod_clk_en_o(clk_en), .bus_wr_i(bwr), .mod_wr_o(mwr),
    .bus_rd_i(brd), .mod_rdata_i(mrdata), .bus_rdata_o(rdata), .bus_rd_valid_o(rvalid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rdata(input logic [N-1:0] en, input logic [N-1:0] rd,
                                              input logic [N*DW-1:0] md);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < N; i++) if (rd[i] && en[i]) r = md[i*DW +: DW];
    return r;
  endfunction

  task automatic check_all();
    logic [DW-1:0] er;
    logic ev;
    er = exp_rdata(exp_en, brd, mrdata);
    ev = |(brd & exp_en);
    chk(dis_rd == exp_dis, "R2 dis readback", 32'(dis_rd), 32'(exp_dis));
    chk(clk_en == exp_en, "R3 clk enable", 32'(clk_en), 32'(exp_en));
    chk((clk_en & ~PRES) == '0, "R4 absent clk", 32'(clk_en), 32'(clk_en & PRES));
    chk(mwr == (bwr & exp_en), "R5 gated write", 32'(mwr), 32'(bwr & exp_en));
    if (brd == '0) begin
      chk(rdata == '0 && !rvalid, "R7 idle read", {15'd0, rvalid, rdata}, 32'd0);
    end else begin
      chk(rdata == er && rvalid == ev, "R6 read", {15'd0, rvalid, rdata}, {15'd0, ev, er});
    end
  endtask

  // drive at negedge, check, then advance the model at posedge
  task automatic step(input bit c, input bit w, input logic [N-1:0] wd,
                      input logic [N-1:0] wr, input logic [N-1:0] rd);
    logic [N-1:0] nxt_en;
    @(negedge clk);
    cyc = c; we = w; wdata = wd; bwr = wr; brd = rd;
    mrdata = {$urandom, $urandom, $urandom, $urandom};
    #1;
    check_all();
    @(posedge clk);
    nxt_en = c ? (~exp_dis & PRES) : exp_en;
    if (w) exp_dis = wd | ~PRES;
    exp_en = nxt_en;
  endtask

  function automatic logic [N-1:0] rand_rd();
    int k = int'($urandom_range(N));
    return (k == int'(N)) ? '0 : N'(1) << k;
  endfunction

  initial begin
    void'($urandom(32'd20240917));
    exp_dis = ~PRES;
    exp_en  = PRES;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(dis_rd == ~PRES, "R1 reset dis", 32'(dis_rd), 32'(~PRES));
    chk(clk_en == PRES, "R1 reset en", 32'(clk_en), 32'(PRES));
    // R6 reads of all present modules right after reset
    for (int i = 0; i < int'(N); i++) step(1'b0, 1'b0, '0, '1, N'(1) << i);
    // R2 absent bits stay set when written 0
    step(1'b0, 1'b1, '0, '0, '0);
    // R3 no strobe: enable must hold for several cycles
    step(1'b0, 1'b1, 8'hFF, '0, '0);
    repeat (4) step(1'b0, 1'b0, '0, '1, rand_rd());
    // R3 apply on strobe, then access blocked
    step(1'b1, 1'b0, '0, '0, '0);
    for (int i = 0; i < int'(N); i++) step(1'b0, 1'b0, '0, '1, N'(1) << i);
    // R3 write at same edge as strobe waits for next strobe
    step(1'b1, 1'b1, 8'h00, '0, '0);
    step(1'b0, 1'b0, '0, '1, 8'h01);
    step(1'b1, 1'b0, '0, '1, 8'h01);
    step(1'b0, 1'b0, '0, '1, 8'h01);
    // random mix
    for (int n = 0; n < 3000; n++)
      step($urandom_range(3) == 0, $urandom_range(4) == 0, N'($urandom), N'($urandom), rand_rd());
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule